// File: doc/BRIEF.md
# Translation Fault Capture and Interrupt

This block sits beside two address-translation engines and records the faults they report. Each engine presents a fault strobe with a vector of fault types, the page number of the faulting virtual address, the physical address, the access direction, the page-table level and the requester (port and group). For every engine the block keeps a status field, a packed fault-address word, a physical-address word and a requester word, and it drives one level interrupt while any enabled fault is recorded.

Software reads a small word-addressed register file. It picks engine 0's captures when engine 0 shows any status bit and engine 1's otherwise; a priority view makes that choice in hardware. The interrupt is released by writing the clear bit of the control register, which also empties the status and re-arms capture. A parameter picks how the requester group is laid out: as a plain 3-bit master number, or as a 3-bit common ID plus a 2-bit sub ID.

Top module: `xlat_fault_capture`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Fault type index k (0 translation, 1 multi-hit, 2 invalid PA, 3 entry replacement, 4 TLB miss, 5 miss-FIFO, 6 prefetch-FIFO) sets status bit k for engine 0 and bit 7+k for engine 1; the status register is at address 2.
- R3: A fault type whose enable bit (address 1, bit 7*engine+k) is 0 leaves the status, the interrupt and the capture words unchanged.
- R4: The fault-address word (engine 0 at address 3, engine 1 at address 6) holds VA bits 31:12 in bits 31:12, VA bits 34:32 in 11:9, PA bits 34:32 in 8:6, the write flag in bit 1, the level in bit 0, zeros elsewhere.
- R5: The physical-address word (addresses 4 and 7) holds PA bits 31:0 of the captured fault.
- R6: The requester word (addresses 5 and 8) holds the port in bits 6:2; with SUB_COMMON=0 the 3-bit master ID (group bits 2:0) sits in bits 9:7, with SUB_COMMON=1 the common ID (group bits 4:2) sits in 11:9 and the sub ID (group bits 1:0) in 8:7.
- R7: An engine's capture words freeze at its first enabled fault; later enabled faults on that engine only OR further status bits in.
- R8: `irq` equals the OR of all status bits ANDed with their enable bits, so lowering an enable masks the interrupt without erasing the status.
- R9: Writing 1 to bit 12 of the control register (address 0) zeroes status and capture words and re-arms capture; bit 12 reads 1 for exactly the following cycle; a fault arriving in the clearing cycle is recorded afresh.
- R10: Control bits 0, 1, 2, 3, 5 and 6 are writable and read back; the other control bits read 0 apart from the clear flag.
- R11: Addresses 9, 10 and 11 show engine 0's fault-address, physical-address and requester words when any engine 0 status bit is set, and engine 1's otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 2 | Fault strobe, one per engine |
| flt_type | input | 2x7 | Fault type vector per engine |
| flt_vpn | input | 2x23 | Virtual page number (VA bits 34:12) per engine |
| flt_pa | input | 2x35 | Physical address per engine |
| flt_write | input | 2 | Access was a write |
| flt_level | input | 2 | Page-table level of the fault |
| flt_port | input | 2x5 | Requester port number |
| flt_grp | input | 2x5 | Requester group code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (read and write) |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level fault interrupt |

## Verification
The main sweep drives every fault type on each engine in turn with distinct address and requester values, once with its enable set and once with only that enable cleared, which separates the status bit mapping, the packing of each capture word and the masking of disabled types. Back-to-back faults on one engine show whether the first capture holds while status accumulates, and faults on both engines against faults on engine 1 alone tell the priority view's two choices apart. A clear issued together with a new fault distinguishes clear-wins from fault-wins ordering, and two instances with different group layouts separate the two requester encodings.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
    localparam int N_ENG   = 2;
    localparam int N_TYPES = 7;
    localparam int VA_W    = 35;
    localparam int PA_W    = 35;
    localparam int PG_SH   = 12;
    localparam int VPN_W   = VA_W - PG_SH;
    localparam int HI_W    = VA_W - 32;
    localparam int PORT_W  = 5;
    localparam int GRP_W   = 5;
    localparam int ID_W    = 2 + PORT_W + GRP_W;
    localparam int STAT_W  = N_ENG * N_TYPES;
    localparam int CLR_BIT = 12;
    localparam logic [6:0] CTRL_MASK = 7'b110_1111;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_INTEN = 4'd1,
        A_STAT  = 4'd2,
        A_E0VA  = 4'd3,
        A_E0PA  = 4'd4,
        A_E0ID  = 4'd5,
        A_E1VA  = 4'd6,
        A_E1PA  = 4'd7,
        A_E1ID  = 4'd8,
        A_SELVA = 4'd9,
        A_SELPA = 4'd10,
        A_SELID = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic [N_TYPES-1:0] st;
        logic               frz;
        logic [31:0]        va_word;
        logic [31:0]        pa_word;
        logic [ID_W-1:0]    id_word;
    } slot_t;

    typedef struct packed {
        logic [6:0]        ctrl;
        logic              clr_flag;
        logic [STAT_W-1:0] int_en;
    } top_t;
endpackage

// File: rtl/fcap_id_pack.sv
module fcap_id_pack
    import fcap_pkg::*;
#(
    parameter bit SUB_COMMON = 1'b1
) (
    input  logic [PORT_W-1:0] port,
    input  logic [GRP_W-1:0]  grp,
    output logic [ID_W-1:0]   id
);
    generate
        if (SUB_COMMON) begin : g_sub
            // common ID at 11:9, sub ID at 8:7, port at 6:2
            assign id = {grp, port, 2'b00};
        end else begin : g_plain
            // master ID at 9:7, port at 6:2
            assign id = {2'b00, grp[2:0], port, 2'b00};
        end
    endgenerate
endmodule

// File: rtl/fcap_slot.sv
module fcap_slot
    import fcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [N_TYPES-1:0] en,
    input  logic               valid,
    input  logic [N_TYPES-1:0] ftype,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [PA_W-1:0]    pa,
    input  logic               wr,
    input  logic               lvl,
    input  logic [ID_W-1:0]    id,
    output logic [N_TYPES-1:0] status,
    output logic [31:0]        va_word,
    output logic [31:0]        pa_word,
    output logic [31:0]        id_word
);
    localparam int LOW_VPN = 32 - PG_SH;

    slot_t s_d, s_q;
    logic [N_TYPES-1:0] hit;

    always_comb begin
        s_d = s_q;
        hit = valid ? (ftype & en) : '0;
        if (clr) s_d = '0;
        s_d.st = s_d.st | hit;
        if ((hit != '0) && !s_d.frz) begin
            s_d.frz     = 1'b1;
            s_d.va_word = {vpn[LOW_VPN-1:0], vpn[VPN_W-1:LOW_VPN],
                           pa[PA_W-1:32], 4'b0000, wr, lvl};
            s_d.pa_word = pa[31:0];
            s_d.id_word = id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status  = s_q.st;
    assign va_word = s_q.va_word;
    assign pa_word = s_q.pa_word;
    assign id_word = {{(32-ID_W){1'b0}}, s_q.id_word};

    // R7
    cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.frz && !clr) |=> ($stable(s_q.va_word) && $stable(s_q.pa_word) && $stable(s_q.id_word)));

    // R7
    status_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((s_q.st & $past(s_q.st)) == $past(s_q.st)));

    // R3
    masked_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ((ftype & en) == '0)) |=> (s_q.st == $past(s_q.st)));

    // R7
    status_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != '0) |-> s_q.frz);
endmodule

// File: rtl/xlat_fault_capture.sv
module xlat_fault_capture
    import fcap_pkg::*;
#(
    parameter bit SUB_COMMON = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_ENG-1:0]                  flt_valid,
    input  logic [N_ENG-1:0][N_TYPES-1:0]     flt_type,
    input  logic [N_ENG-1:0][VPN_W-1:0]       flt_vpn,
    input  logic [N_ENG-1:0][PA_W-1:0]        flt_pa,
    input  logic [N_ENG-1:0]                  flt_write,
    input  logic [N_ENG-1:0]                  flt_level,
    input  logic [N_ENG-1:0][PORT_W-1:0]      flt_port,
    input  logic [N_ENG-1:0][GRP_W-1:0]       flt_grp,
    input  logic                              reg_wr,
    input  logic [3:0]                        reg_addr,
    input  logic [STAT_W-1:0]                 reg_wdata,
    output logic [31:0]                       reg_rdata,
    output logic                              irq
);
    top_t t_d, t_q;
    logic clear_w;

    logic [N_ENG-1:0][N_TYPES-1:0] st_w;
    logic [N_ENG-1:0][31:0]        va_w;
    logic [N_ENG-1:0][31:0]        pa_w;
    logic [N_ENG-1:0][31:0]        id_w;
    logic [STAT_W-1:0]             st_all;
    logic                          pick0;

    assign clear_w = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CLR_BIT];

    generate
        for (genvar g = 0; g < N_ENG; g++) begin : g_eng
            logic [ID_W-1:0] id_g;
            fcap_id_pack #(.SUB_COMMON(SUB_COMMON)) u_id (
                .port (flt_port[g]),
                .grp  (flt_grp[g]),
                .id   (id_g)
            );
            fcap_slot u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clear_w),
                .en      (t_q.int_en[g*N_TYPES +: N_TYPES]),
                .valid   (flt_valid[g]),
                .ftype   (flt_type[g]),
                .vpn     (flt_vpn[g]),
                .pa      (flt_pa[g]),
                .wr      (flt_write[g]),
                .lvl     (flt_level[g]),
                .id      (id_g),
                .status  (st_w[g]),
                .va_word (va_w[g]),
                .pa_word (pa_w[g]),
                .id_word (id_w[g])
            );
        end
    endgenerate

    assign st_all = st_w;
    assign pick0  = (st_w[0] != '0);

    always_comb begin
        t_d          = t_q;
        t_d.clr_flag = clear_w;
        if (reg_wr && (reg_addr == A_CTRL))  t_d.ctrl   = reg_wdata[6:0] & CTRL_MASK;
        if (reg_wr && (reg_addr == A_INTEN)) t_d.int_en = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign irq = |(st_all & t_q.int_en);

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {19'b0, t_q.clr_flag, 5'b0, t_q.ctrl};
            A_INTEN: reg_rdata = {{(32-STAT_W){1'b0}}, t_q.int_en};
            A_STAT:  reg_rdata = {{(32-STAT_W){1'b0}}, st_all};
            A_E0VA:  reg_rdata = va_w[0];
            A_E0PA:  reg_rdata = pa_w[0];
            A_E0ID:  reg_rdata = id_w[0];
            A_E1VA:  reg_rdata = va_w[1];
            A_E1PA:  reg_rdata = pa_w[1];
            A_E1ID:  reg_rdata = id_w[1];
            A_SELVA: reg_rdata = pick0 ? va_w[0] : va_w[1];
            A_SELPA: reg_rdata = pick0 ? pa_w[0] : pa_w[1];
            A_SELID: reg_rdata = pick0 ? id_w[0] : id_w[1];
            default: reg_rdata = '0;
        endcase
    end

    // R9
    clr_selfreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.clr_flag && !clear_w) |=> !t_q.clr_flag);

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_w && (flt_valid == '0)) |=> ((st_all == '0) && !irq));

    // R8
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_all != '0));

    // R10
    ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (t_q.ctrl[4] == 1'b0));
endmodule

// File: tb/tb_xlat_fault_capture.sv
module tb_xlat_fault_capture;
    import fcap_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_ENG-1:0]              flt_valid = '0;
    logic [N_ENG-1:0][N_TYPES-1:0] flt_type = '0;
    logic [N_ENG-1:0][VPN_W-1:0]   flt_vpn = '0;
    logic [N_ENG-1:0][PA_W-1:0]    flt_pa = '0;
    logic [N_ENG-1:0]              flt_write = '0;
    logic [N_ENG-1:0]              flt_level = '0;
    logic [N_ENG-1:0][PORT_W-1:0]  flt_port = '0;
    logic [N_ENG-1:0][GRP_W-1:0]   flt_grp = '0;
    logic              reg_wr = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [STAT_W-1:0] reg_wdata = '0;
    logic [31:0]       rdata, rdata_lb;
    logic              irq, irq_lb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    xlat_fault_capture dut (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_type(flt_type),
        .flt_vpn(flt_vpn), .flt_pa(flt_pa), .flt_write(flt_write), .flt_level(flt_level),
        .flt_port(flt_port), .flt_grp(flt_grp), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq)
    );

    xlat_fault_capture #(.SUB_COMMON(1'b0)) dut_lb (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_type(flt_type),
        .flt_vpn(flt_vpn), .flt_pa(flt_pa), .flt_write(flt_write), .flt_level(flt_level),
        .flt_port(flt_port), .flt_grp(flt_grp), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_lb), .irq(irq_lb)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v, output logic [31:0] v_lb);
        reg_addr = a;
        #1;
        v = rdata;
        v_lb = rdata_lb;
    endtask

    task automatic wr(input logic [3:0] a, input logic [STAT_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        wr(A_CTRL, STAT_W'(1 << CLR_BIT));
    endtask

    task automatic set_eng(input int e, input logic [N_TYPES-1:0] t, input logic [VPN_W-1:0] v,
                           input logic [PA_W-1:0] p, input logic w, input logic l,
                           input logic [PORT_W-1:0] po, input logic [GRP_W-1:0] gr);
        flt_type[e] = t; flt_vpn[e] = v; flt_pa[e] = p;
        flt_write[e] = w; flt_level[e] = l; flt_port[e] = po; flt_grp[e] = gr;
    endtask

    task automatic fire(input logic [N_ENG-1:0] m);
        @(negedge clk);
        flt_valid = m;
        @(negedge clk);
        flt_valid = '0;
    endtask

    function automatic logic [31:0] exp_va(input logic [VPN_W-1:0] v, input logic [PA_W-1:0] p,
                                           input logic w, input logic l);
        return {v[19:0], v[22:20], p[34:32], 4'b0000, w, l};
    endfunction

    function automatic logic [31:0] exp_id_sub(input logic [PORT_W-1:0] po, input logic [GRP_W-1:0] gr);
        return {20'b0, gr[4:2], gr[1:0], po, 2'b00};
    endfunction

    function automatic logic [31:0] exp_id_plain(input logic [PORT_W-1:0] po, input logic [GRP_W-1:0] gr);
        return {22'b0, gr[2:0], po, 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, vl;
        logic [VPN_W-1:0] vpn_a, vpn_b;
        logic [PA_W-1:0]  pa_a, pa_b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v, vl);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);

        wr(A_INTEN, '1);

        // R2 R3 R4 R5 R6 R8 sweep over engines and fault types
        for (int e = 0; e < N_ENG; e++) begin
            for (int k = 0; k < N_TYPES; k++) begin
                logic [VPN_W-1:0] vv;
                logic [PA_W-1:0]  pp;
                logic [PORT_W-1:0] po;
                logic [GRP_W-1:0]  gr;
                vv = {3'(k + e + 1), 20'(20'h0ABCD + k * 4097 + e * 31)};
                pp = {3'(7 - k), 32'(32'hF000_0000 | (k << 8) | (e << 4) | 3)};
                po = 5'(k * 3 + e);
                gr = 5'(k * 5 + e * 11 + 1);

                clear_all();
                set_eng(e, N_TYPES'(1 << k), vv, pp, k[0], k[1], po, gr);
                fire(N_ENG'(1 << e));
                rd(A_STAT, v, vl);
                check("R2 status bit", v, 32'(1 << (e * N_TYPES + k)));
                check("R8 irq raised", {31'b0, irq}, 32'h1);
                rd(e ? A_E1VA : A_E0VA, v, vl);
                check("R4 va word", v, exp_va(vv, pp, k[0], k[1]));
                rd(e ? A_E1PA : A_E0PA, v, vl);
                check("R5 pa word", v, pp[31:0]);
                rd(e ? A_E1ID : A_E0ID, v, vl);
                check("R6 id sub-common", v, exp_id_sub(po, gr));
                check("R6 id plain", vl, exp_id_plain(po, gr));

                // R3 same fault with only its enable cleared
                wr(A_INTEN, STAT_W'(~(1 << (e * N_TYPES + k))));
                clear_all();
                fire(N_ENG'(1 << e));
                rd(A_STAT, v, vl);
                check("R3 disabled status", v, 32'h0);
                check("R3 disabled irq", {31'b0, irq}, 32'h0);
                rd(e ? A_E1VA : A_E0VA, v, vl);
                check("R3 disabled capture", v, 32'h0);
                wr(A_INTEN, '1);
            end
        end

        // R7 freeze at first fault
        clear_all();
        vpn_a = 23'h12_3456; pa_a = 35'h2_1111_2222;
        vpn_b = 23'h65_4321; pa_b = 35'h5_3333_4444;
        set_eng(0, 7'b000_0001, vpn_a, pa_a, 1'b1, 1'b0, 5'd9, 5'd3);
        fire(2'b01);
        set_eng(0, 7'b001_0000, vpn_b, pa_b, 1'b0, 1'b1, 5'd20, 5'd30);
        fire(2'b01);
        rd(A_STAT, v, vl);
        check("R7 status accumulates", v, 32'h11);
        rd(A_E0VA, v, vl);
        check("R7 va frozen", v, exp_va(vpn_a, pa_a, 1'b1, 1'b0));
        rd(A_E0PA, v, vl);
        check("R7 pa frozen", v, pa_a[31:0]);
        rd(A_E0ID, v, vl);
        check("R7 id frozen", v, exp_id_sub(5'd9, 5'd3));

        // R8 masking after capture keeps status, drops irq
        wr(A_INTEN, 14'h3FFF & ~14'h11);
        rd(A_STAT, v, vl);
        check("R8 status kept", v, 32'h11);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(A_INTEN, 14'h0010);
        check("R8 irq partial enable", {31'b0, irq}, 32'h1);
        wr(A_INTEN, '1);

        // R11 priority view
        clear_all();
        set_eng(0, 7'b000_0100, vpn_a, pa_a, 1'b0, 1'b0, 5'd1, 5'd2);
        set_eng(1, 7'b100_0000, vpn_b, pa_b, 1'b1, 1'b1, 5'd4, 5'd5);
        fire(2'b11);
        rd(A_STAT, v, vl);
        check("R2 both engines", v, 32'h2004);
        rd(A_SELVA, v, vl);
        check("R11 select engine 0 va", v, exp_va(vpn_a, pa_a, 1'b0, 1'b0));
        rd(A_SELPA, v, vl);
        check("R11 select engine 0 pa", v, pa_a[31:0]);
        clear_all();
        fire(2'b10);
        rd(A_SELVA, v, vl);
        check("R11 select engine 1 va", v, exp_va(vpn_b, pa_b, 1'b1, 1'b1));
        rd(A_SELID, v, vl);
        check("R11 select engine 1 id", v, exp_id_sub(5'd4, 5'd5));
        check("R11 plain id engine 1", vl, exp_id_plain(5'd4, 5'd5));

        // R9 clear pulse and clear emptying
        clear_all();
        rd(A_CTRL, v, vl);
        check("R9 clear flag high", v, 32'h1000);
        rd(A_STAT, v, vl);
        check("R9 status emptied", v, 32'h0);
        check("R9 irq released", {31'b0, irq}, 32'h0);
        rd(A_E1VA, v, vl);
        check("R9 capture emptied", v, 32'h0);
        @(negedge clk);
        rd(A_CTRL, v, vl);
        check("R9 clear flag self-reset", v, 32'h0);

        // R9 fault in the clearing cycle is recorded afresh
        set_eng(0, 7'b000_0001, vpn_a, pa_a, 1'b0, 1'b0, 5'd1, 5'd1);
        fire(2'b01);
        set_eng(0, 7'b000_0100, vpn_b, pa_b, 1'b1, 1'b0, 5'd2, 5'd2);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = STAT_W'(1 << CLR_BIT);
        flt_valid = 2'b01;
        @(negedge clk);
        reg_wr = 1'b0; flt_valid = '0;
        rd(A_STAT, v, vl);
        check("R9 same-cycle fault status", v, 32'h4);
        rd(A_E0VA, v, vl);
        check("R9 same-cycle fault capture", v, exp_va(vpn_b, pa_b, 1'b1, 1'b0));
        check("R9 same-cycle irq", {31'b0, irq}, 32'h1);

        // R10 control readback
        wr(A_CTRL, 14'h2FFF);
        rd(A_CTRL, v, vl);
        check("R10 ctrl writable bits", v, 32'h006F);
        wr(A_CTRL, 14'h0012);
        rd(A_CTRL, v, vl);
        check("R10 ctrl reserved bit 4", v, 32'h0002);
        rd(A_STAT, v, vl);
        check("R10 ctrl write without clear keeps status", v, 32'h4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule